// File: doc/BRIEF.md
# Watchdog Supervisor with Level Disable

This block watches a microcontroller's heartbeat line through two comparator results. One result tells whether the line sits above a middle threshold. The other tells whether it sits above a high disable threshold. A saturating counter stands in for an analog timing ramp. Every time the middle result changes, in either direction, the counter is cleared and then held at zero for a fixed window. Once the window ends, the counter climbs again.

If the counter reaches its timeout level while supervision is active, the block pulls an active-low reset line low for a fixed pulse. It also clears the counter and holds it at zero for the same window that follows an edge. Holding the line above the high threshold turns supervision off. The counter still climbs and parks at its maximum, but no reset pulse is produced.

Clock frequency, timeout, hold window and pulse length are parameters given in hertz and microseconds. They are converted to cycle counts when the block is built. Both comparator results are asynchronous and pass through two-flop synchronisers before any decision is made.

Top module: `wdog_supervisor`

## Requirements
- R1: With `rst` high, `timer_o` is 0 and `rst_n_o` is 1, whatever state the block was in.
- R2: When no hold is active, `timer_o` rises by one per clock. It saturates at the timeout count TO = CLK_HZ*TIMEOUT_US/1e6 and never wraps.
- R3: A low-to-high change of `cmp_mid_i` clears `timer_o` to 0 on the third rising clock edge after the change, counting the two synchroniser stages. The timer then stays at 0 for HOLD = CLK_HZ*HOLD_US/1e6 further clocks before it counts again.
- R4: A high-to-low change of `cmp_mid_i` has the same effect as in R3: the timer is cleared three clocks later and held for HOLD clocks.
- R5: A change of `cmp_high_i` while `cmp_mid_i` stays constant does not clear or hold the timer.
- R6: When `timer_o` equals TO and supervision is active, the next clock does two things. It clears the timer and holds it for HOLD clocks, and it drives `rst_n_o` low for exactly PULSE = CLK_HZ*PULSE_US/1e6 clocks. Counting resumes after `rst_n_o` is back high.
- R7: While the synchronised `cmp_high_i` is 1, no timeout occurs. The timer saturates at TO and `rst_n_o` stays 1.
- R8: If both inputs fall in the same cycle while the timer is saturated, the middle-threshold edge takes priority over the timeout. The timer is cleared and held, and `rst_n_o` stays 1.
- R9: If `cmp_high_i` falls while `cmp_mid_i` stays high and the timer sits at TO, a timeout follows. `rst_n_o` goes low on the clock after the synchronised high result drops.
- R10: Asserting `rst` during a reset pulse ends the pulse at once and returns the block to the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_mid_i | input | 1 | Asynchronous result of the middle-threshold comparator |
| cmp_high_i | input | 1 | Asynchronous result of the high disable comparator |
| rst_n_o | output | 1 | Active-low reset pulse to the supervised controller |
| timer_o | output | TW | Current ramp counter value, TW = clog2(TO+1) |

## Verification
The main function is driven with four kinds of pattern: rising middle edges, falling middle edges, a heartbeat that stops until timeout, and toggling of only the high input. Together these separate a real threshold crossing from a swing that stays on one side of the threshold. Exact cycle sampling around each edge shows that the hold window lasts precisely HOLD clocks. Around a timeout it shows that the pulse lasts precisely PULSE clocks. Holding the high input with a stalled heartbeat separates saturation without a pulse from a wrapping or firing counter. The two exits from the disabled state then tell edge-over-timeout priority (both inputs drop together) apart from an immediate timeout (only the high input drops).

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

    typedef struct packed {
        logic mid;
        logic high;
    } cmp_t;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic int cyc_of(input longint hz, input longint us);
        return int'((hz * us) / 64'd1000000);
    endfunction

    function automatic int width_of(input int n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/wdsup_sync.sv
module wdsup_sync
    import wdsup_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmp_t raw_i,
    output cmp_t sync_o
);
    localparam int NB = $bits(cmp_t);

    logic [NB-1:0] stage1;
    logic [NB-1:0] stage2;

    for (genvar b = 0; b < NB; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1[b] <= 1'b0;
                stage2[b] <= 1'b0;
            end else begin
                stage1[b] <= raw_i[b];
                stage2[b] <= stage1[b];
            end
        end
    end

    assign sync_o = cmp_t'(stage2);
endmodule

// File: rtl/wdsup_edge.sv
module wdsup_edge
    import wdsup_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  lvl_i,
    output edge_t edge_o
);
    logic prev;

    always_ff @(posedge clk) begin
        if (rst) prev <= 1'b0;
        else     prev <= lvl_i;
    end

    always_comb begin
        edge_o.rise = lvl_i & ~prev;
        edge_o.fall = ~lvl_i & prev;
    end

    // R4
    fall_once_chk: assert property (@(posedge clk) disable iff (rst)
        edge_o.fall |=> !edge_o.fall);
endmodule

// File: rtl/wdsup_timer.sv
module wdsup_timer #(
    parameter int TO_CYC   = 40,
    parameter int HOLD_CYC = 15,
    parameter int TW       = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          kick_i,
    input  logic          enable_i,
    output logic [TW-1:0] timer_o,
    output logic          timeout_o
);
    localparam int HW = wdsup_pkg::width_of(HOLD_CYC);
    localparam logic [TW-1:0] TMAX  = TW'(TO_CYC);
    localparam logic [HW-1:0] HLOAD = HW'(HOLD_CYC);

    logic [TW-1:0] timer_q;
    logic [HW-1:0] hold_q;
    logic          clear;

    always_comb begin
        timeout_o = enable_i && !kick_i && (hold_q == '0) && (timer_q == TMAX);
        clear     = kick_i || timeout_o;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            timer_q <= '0;
            hold_q  <= '0;
        end else if (clear) begin
            timer_q <= '0;
            hold_q  <= HLOAD;
        end else if (hold_q != '0) begin
            hold_q  <= hold_q - HW'(1);
        end else if (timer_q != TMAX) begin
            timer_q <= timer_q + TW'(1);
        end
    end

    assign timer_o = timer_q;

    // R2
    timer_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (timer_q == TMAX && !clear) |=> timer_q == TMAX);

    // R3
    kick_zero_chk: assert property (@(posedge clk) disable iff (rst)
        kick_i |=> timer_q == '0);

    // R3
    hold_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_q != '0) |-> timer_q == '0);
endmodule

// File: rtl/wdsup_pulse.sv
module wdsup_pulse #(
    parameter int PULSE_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic fire_i,
    output logic rst_n_o
);
    localparam int PW = wdsup_pkg::width_of(PULSE_CYC);
    localparam logic [PW-1:0] PLOAD = PW'(PULSE_CYC);

    logic [PW-1:0] left_q;

    always_ff @(posedge clk) begin
        if (rst)                left_q <= '0;
        else if (fire_i)        left_q <= PLOAD;
        else if (left_q != '0)  left_q <= left_q - PW'(1);
    end

    assign rst_n_o = (left_q == '0);

    // R6
    fire_low_chk: assert property (@(posedge clk) disable iff (rst)
        fire_i |=> !rst_n_o);
endmodule

// File: rtl/wdog_supervisor.sv
module wdog_supervisor
    import wdsup_pkg::*;
#(
    parameter longint CLK_HZ     = 100000000,
    parameter longint TIMEOUT_US = 1600,
    parameter longint HOLD_US    = 1500,
    parameter longint PULSE_US   = 1000,
    localparam int TO_CYC    = cyc_of(CLK_HZ, TIMEOUT_US),
    localparam int HOLD_CYC  = cyc_of(CLK_HZ, HOLD_US),
    localparam int PULSE_CYC = cyc_of(CLK_HZ, PULSE_US),
    localparam int TW        = width_of(TO_CYC)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmp_mid_i,
    input  logic          cmp_high_i,
    output logic          rst_n_o,
    output logic [TW-1:0] timer_o
);
    cmp_t  raw;
    cmp_t  synced;
    edge_t mid_edge;
    logic  kick;
    logic  timeout;

    assign raw.mid  = cmp_mid_i;
    assign raw.high = cmp_high_i;

    wdsup_sync u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_i  (raw),
        .sync_o (synced)
    );

    wdsup_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .lvl_i  (synced.mid),
        .edge_o (mid_edge)
    );

    assign kick = mid_edge.rise | mid_edge.fall;

    wdsup_timer #(
        .TO_CYC   (TO_CYC),
        .HOLD_CYC (HOLD_CYC),
        .TW       (TW)
    ) u_timer (
        .clk       (clk),
        .rst       (rst),
        .kick_i    (kick),
        .enable_i  (!synced.high),
        .timer_o   (timer_o),
        .timeout_o (timeout)
    );

    wdsup_pulse #(
        .PULSE_CYC (PULSE_CYC)
    ) u_pulse (
        .clk     (clk),
        .rst     (rst),
        .fire_i  (timeout),
        .rst_n_o (rst_n_o)
    );

    // R7
    disabled_no_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_n_o) |-> !$past(synced.high));

    // R8
    edge_beats_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> rst_n_o || !$past(rst_n_o) || $past(timeout));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (rst_n_o && timer_o == '0));
endmodule

// File: tb/sim_wdog_supervisor.sv
module sim_wdog_supervisor;
    import wdsup_pkg::*;

    localparam longint HZ = 1000000;
    localparam int TW = width_of(cyc_of(HZ, 40));

    typedef struct packed {
        logic       mid;
        logic       high;
        logic [7:0] wt;
        logic [7:0] exp_t;
        logic       exp_r;
        logic [3:0] req;
    } vec_t;

    // TO=40, HOLD=15, PULSE=10 clocks
    localparam vec_t VEC [22] = '{
        '{1'b0, 1'b0, 8'd10, 8'd10, 1'b1, 4'd2},  // R2 free count
        '{1'b1, 1'b0, 8'd3,  8'd0,  1'b1, 4'd3},  // R3 rise clears
        '{1'b1, 1'b0, 8'd15, 8'd0,  1'b1, 4'd3},  // R3 hold window
        '{1'b1, 1'b0, 8'd5,  8'd5,  1'b1, 4'd2},  // R2 resumes
        '{1'b0, 1'b0, 8'd3,  8'd0,  1'b1, 4'd4},  // R4 fall clears
        '{1'b0, 1'b0, 8'd20, 8'd5,  1'b1, 4'd4},  // R4 hold then count
        '{1'b0, 1'b0, 8'd35, 8'd40, 1'b1, 4'd6},  // R6 reaches TO
        '{1'b0, 1'b0, 8'd1,  8'd0,  1'b0, 4'd6},  // R6 pulse starts
        '{1'b0, 1'b0, 8'd9,  8'd0,  1'b0, 4'd6},  // R6 pulse last cycle
        '{1'b0, 1'b0, 8'd1,  8'd0,  1'b1, 4'd6},  // R6 pulse ends, hold on
        '{1'b0, 1'b0, 8'd10, 8'd5,  1'b1, 4'd6},  // R6 counting resumes
        '{1'b1, 1'b1, 8'd3,  8'd0,  1'b1, 4'd3},  // R3 rise with disable
        '{1'b1, 1'b1, 8'd75, 8'd40, 1'b1, 4'd7},  // R7 saturate, no pulse
        '{1'b0, 1'b0, 8'd3,  8'd0,  1'b1, 4'd8},  // R8 edge wins
        '{1'b0, 1'b0, 8'd20, 8'd5,  1'b1, 4'd4},  // R4 hold after re-enable
        '{1'b1, 1'b0, 8'd3,  8'd0,  1'b1, 4'd3},  // R3
        '{1'b1, 1'b0, 8'd20, 8'd5,  1'b1, 4'd3},  // R3
        '{1'b1, 1'b1, 8'd5,  8'd10, 1'b1, 4'd5},  // R5 high rises only
        '{1'b1, 1'b0, 8'd5,  8'd15, 1'b1, 4'd5},  // R5 high falls only
        '{1'b1, 1'b1, 8'd30, 8'd40, 1'b1, 4'd7},  // R7 saturate
        '{1'b1, 1'b0, 8'd2,  8'd40, 1'b1, 4'd9},  // R9 enable seen
        '{1'b1, 1'b0, 8'd1,  8'd0,  1'b0, 4'd9}   // R9 timeout fires
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mid = 1'b0;
    logic          high = 1'b0;
    logic          rst_n;
    logic [TW-1:0] timer;

    int total = 0;
    int bad   = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    wdog_supervisor #(
        .CLK_HZ     (HZ),
        .TIMEOUT_US (40),
        .HOLD_US    (15),
        .PULSE_US   (10)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .cmp_mid_i  (mid),
        .cmp_high_i (high),
        .rst_n_o    (rst_n),
        .timer_o    (timer)
    );

    task automatic check(input int req, input int exp_t, input logic exp_r);
        total++;
        if (int'(timer) != exp_t || rst_n !== exp_r) begin
            bad++;
            $display("FAIL R%0d: timer=%0d rst_n=%0b expected timer=%0d rst_n=%0b",
                     req, timer, rst_n, exp_t, exp_r);
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            total++;
            bad++;
            $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1, 0, 1'b1);        // R1 during reset
        rst = 1'b0;
        check(1, 0, 1'b1);        // R1 just released

        for (int i = 0; i < 22; i++) begin
            mid  = VEC[i].mid;
            high = VEC[i].high;
            for (int k = 0; k < int'(VEC[i].wt); k++) @(negedge clk);
            check(int'(VEC[i].req), int'(VEC[i].exp_t), VEC[i].exp_r);
        end

        // R10: reset in the middle of the pulse
        repeat (3) @(negedge clk);
        check(6, 0, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        check(10, 0, 1'b1);
        rst  = 1'b0;
        mid  = 1'b0;
        high = 1'b0;
        @(negedge clk);
        check(10, 1, 1'b1);       // R10 counts from zero at once, no hold

        // R2: saturation with supervision active only lasts one cycle before timeout
        repeat (39) @(negedge clk);
        check(2, 40, 1'b1);
        @(negedge clk);
        check(6, 0, 1'b0);

        finish_run();
    end
endmodule